// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address and register-number stream for a multi-register load or store. A control unit gives it a base address, a 16-bit register mask, one of four addressing modes and a writeback request, and pulses a start strobe. The sequencer then emits one beat per clock cycle. Each beat carries a memory address and the index of the register to move. When the last selected register has been covered, it pulses a completion flag and can also present the updated base value.

Registers always go out in ascending index order, and the lowest-numbered register always takes the lowest address. This holds in the decrementing modes as well, where the block first moves down to the bottom of the memory span and then walks upward. Memory, the register file and any status or privilege handling belong to the surrounding pipeline. The four modes cover the usual stack disciplines for loads: a full-descending stack pops with increment-after, an empty-descending stack with increment-before, a full-ascending stack with decrement-after, and an empty-ascending stack with decrement-before.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy_o`, `beat_valid_o`, `done_o` and `wb_valid_o` are all low.
- R2: With N bits set in the mask, the first beat's address depends on `mode_i`. For 2'b00 (increment after) it is base. For 2'b01 (increment before) it is base+4. For 2'b10 (decrement after) it is base-4N+4. For 2'b11 (decrement before) it is base-4N. All arithmetic is modulo 2^32.
- R3: The first beat appears in the cycle after the edge that accepts start, and one beat follows in every cycle after that. Register indices rise strictly from beat to beat, and each beat's address is 4 above the previous one.
- R4: A run emits exactly N beats, one for each set bit of the mask. `beat_last_o` is high on the final beat only.
- R5: `done_o` is high for exactly the one cycle after the final beat, and `busy_o` is low in that cycle.
- R6: If `wback_i` was high at start, `wb_valid_o` is high together with `done_o`, and `wb_base_o` holds base+4N for modes 2'b00 and 2'b01, or base-4N for modes 2'b10 and 2'b11. If `wback_i` was low, `wb_valid_o` stays low.
- R7: An empty mask produces no beats, raises `done_o` in the cycle after start, and leaves `wb_valid_o` low.
- R8: A start strobe that arrives while `busy_o` is high is ignored. The running sequence keeps its addresses and indices, and no new run begins after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted while not busy |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register selection mask, bit i selects register i |
| mode_i | input | 2 | Addressing mode (see R2) |
| wback_i | input | 1 | Request the updated base at the end |
| busy_o | output | 1 | A run with beats is in progress |
| beat_valid_o | output | 1 | Beat outputs are valid this cycle |
| beat_addr_o | output | 32 | Memory address of this beat |
| beat_reg_o | output | 4 | Register index of this beat |
| beat_last_o | output | 1 | This beat is the final one |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Updated base is valid (with done) |
| wb_base_o | output | 32 | Updated base value |

## Verification
A fixed table covers each mode with a full mask, single registers at both ends of the mask, and a sparse mask. These cases separate errors in the start offset from errors in the walk order or the step, and a decrement run from base zero exposes address wrap. Random masks in all four modes, with writeback on and off, are compared beat by beat against an ascending-walk reference model, which catches wrong counts and wrong last-beat flags. Directed cases cover the empty mask, a start strobe during a run, and the reset state.

// File: rtl/bts_pkg.sv
package bts_pkg;

    // bit 1: address moves downward, bit 0: step before access
    typedef enum logic [1:0] {
        BTS_INC_AFTER  = 2'b00,
        BTS_INC_BEFORE = 2'b01,
        BTS_DEC_AFTER  = 2'b10,
        BTS_DEC_BEFORE = 2'b11
    } bts_mode_e;

    // stack discipline aliases for pops
    localparam bts_mode_e BTS_POP_FULL_DOWN  = BTS_INC_AFTER;
    localparam bts_mode_e BTS_POP_EMPTY_DOWN = BTS_INC_BEFORE;
    localparam bts_mode_e BTS_POP_FULL_UP    = BTS_DEC_AFTER;
    localparam bts_mode_e BTS_POP_EMPTY_UP   = BTS_DEC_BEFORE;

    typedef enum logic {
        BTS_IDLE = 1'b0,
        BTS_RUN  = 1'b1
    } bts_state_e;

endpackage

// File: rtl/bts_popcount.sv
module bts_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/bts_lowest.sv
module bts_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign rest_o = mask_i & (mask_i - W'(1));
endmodule

// File: rtl/bts_addr_plan.sv
module bts_addr_plan
    import bts_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  bts_mode_e     mode_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] wb_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count_i) * STEP;
        unique case (mode_i)
            BTS_INC_AFTER:  first_o = base_i;
            BTS_INC_BEFORE: first_o = base_i + STEP;
            BTS_DEC_AFTER:  first_o = base_i - span + STEP;
            default:        first_o = base_i - span;
        endcase
        wb_o = mode_i[1] ? (base_i - span) : (base_i + span);
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIST_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [LIST_W-1:0]         list_i,
    input  logic [1:0]                mode_i,
    input  logic                      wback_i,
    output logic                      busy_o,
    output logic                      beat_valid_o,
    output logic [ADDR_W-1:0]         beat_addr_o,
    output logic [$clog2(LIST_W)-1:0] beat_reg_o,
    output logic                      beat_last_o,
    output logic                      done_o,
    output logic                      wb_valid_o,
    output logic [ADDR_W-1:0]         wb_base_o
);
    localparam int IDX_W = $clog2(LIST_W);
    localparam int CNT_W = $clog2(LIST_W + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        bts_state_e        st;
        logic [LIST_W-1:0] mask;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb_addr;
        logic              wb_en;
        logic              done;
        logic              wb_valid;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CNT_W-1:0]  sel_count;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_wb;
    logic [IDX_W-1:0]  cur_idx;
    logic [LIST_W-1:0] mask_rest;

    bts_popcount #(.W(LIST_W), .CW(CNT_W)) u_count (
        .vec_i   (list_i),
        .count_o (sel_count)
    );

    bts_addr_plan #(.AW(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i  (base_i),
        .count_i (sel_count),
        .mode_i  (bts_mode_e'(mode_i)),
        .first_o (plan_first),
        .wb_o    (plan_wb)
    );

    bts_lowest #(.W(LIST_W), .IW(IDX_W)) u_pick (
        .mask_i (seq_q.mask),
        .idx_o  (cur_idx),
        .rest_o (mask_rest)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.done     = 1'b0;
        seq_d.wb_valid = 1'b0;
        unique case (seq_q.st)
            BTS_IDLE: begin
                if (start_i) begin
                    seq_d.mask    = list_i;
                    seq_d.addr    = plan_first;
                    seq_d.wb_addr = plan_wb;
                    seq_d.wb_en   = wback_i;
                    if (list_i == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st = BTS_RUN;
                    end
                end
            end
            default: begin
                seq_d.mask = mask_rest;
                seq_d.addr = seq_q.addr + STEP;
                if (mask_rest == '0) begin
                    seq_d.st       = BTS_IDLE;
                    seq_d.done     = 1'b1;
                    seq_d.wb_valid = seq_q.wb_en;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o       = (seq_q.st == BTS_RUN);
    assign beat_valid_o = (seq_q.st == BTS_RUN);
    assign beat_addr_o  = seq_q.addr;
    assign beat_reg_o   = cur_idx;
    assign beat_last_o  = (seq_q.st == BTS_RUN) && (mask_rest == '0);
    assign done_o       = seq_q.done;
    assign wb_valid_o   = seq_q.wb_valid;
    assign wb_base_o    = seq_q.wb_addr;

endmodule

// File: rtl/bts_chk.sv
module bts_chk #(
    parameter int ADDR_W     = 32,
    parameter int LIST_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic [LIST_W-1:0]         list_i,
    input logic                      busy_o,
    input logic                      beat_valid_o,
    input logic [ADDR_W-1:0]         beat_addr_o,
    input logic [$clog2(LIST_W)-1:0] beat_reg_o,
    input logic                      beat_last_o,
    input logic                      done_o,
    input logic                      wb_valid_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && $past(beat_valid_o) |-> beat_addr_o == $past(beat_addr_o) + STEP);

    // R3
    reg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && $past(beat_valid_o) |-> beat_reg_o > $past(beat_reg_o));

    // R5
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_last_o |=> done_o && !busy_o);

    // R6
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R7
    empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && list_i == '0 |=> done_o && !beat_valid_o && !wb_valid_o);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !beat_last_o |=> busy_o);

endmodule

bind blk_xfer_seq bts_chk #(
    .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .list_i       (list_i),
    .busy_o       (busy_o),
    .beat_valid_o (beat_valid_o),
    .beat_addr_o  (beat_addr_o),
    .beat_reg_o   (beat_reg_o),
    .beat_last_o  (beat_last_o),
    .done_o       (done_o),
    .wb_valid_o   (wb_valid_o)
);

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wback_i = 1'b0;
    logic        busy_o, beat_valid_o, beat_last_o, done_o, wb_valid_o;
    logic [31:0] beat_addr_o, wb_base_o;
    logic [3:0]  beat_reg_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    blk_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .list_i(list_i), .mode_i(mode_i), .wback_i(wback_i),
        .busy_o(busy_o), .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
        .beat_reg_o(beat_reg_o), .beat_last_o(beat_last_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
    );

    // {mode[50:49], wback[48], list[47:32], base[31:0]}
    localparam logic [50:0] VECS [0:7] = '{
        {2'b00, 1'b1, 16'hFFFF, 32'h0000_1000},
        {2'b01, 1'b1, 16'h0001, 32'h0000_2000},
        {2'b10, 1'b1, 16'h8000, 32'h0000_3000},
        {2'b11, 1'b1, 16'h8421, 32'h0000_4000},
        {2'b11, 1'b1, 16'h0003, 32'h0000_0000},
        {2'b10, 1'b0, 16'hFFFF, 32'h0000_5000},
        {2'b01, 1'b1, 16'hA5A5, 32'hFFFF_FFF0},
        {2'b00, 1'b0, 16'h4002, 32'h0001_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives one run; intr_at >= 0 pulses a stray start during that beat
    task automatic run_case(input logic [1:0] mode, input logic wb, input logic [15:0] list,
                            input logic [31:0] base, input int intr_at);
        int          n;
        logic [31:0] first, span, exp_wb, a;
        int          k;
        n    = $countones(list);
        span = 32'(n) * 32'd4;
        case (mode)
            2'b00:   first = base;
            2'b01:   first = base + 32'd4;
            2'b10:   first = base - span + 32'd4;
            default: first = base - span;
        endcase
        exp_wb = mode[1] ? base - span : base + span;
        @(negedge clk);
        start_i = 1'b1; base_i = base; list_i = list; mode_i = mode; wback_i = wb;
        @(negedge clk);
        start_i = 1'b0;
        a = first;
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (list[i]) begin
                // R2 R3 R4: {valid,last,reg,addr}
                check("R3", {26'd0, beat_valid_o, beat_last_o, beat_reg_o, beat_addr_o},
                      {26'd0, 1'b1, (k == n - 1), 4'(i), a});
                if (k == 0) check("R2", {32'd0, beat_addr_o}, {32'd0, first});
                if (k == intr_at) begin
                    start_i = 1'b1; base_i = 32'h0BAD_0000; list_i = 16'h0001; mode_i = 2'b11;
                end
                @(negedge clk);
                start_i = 1'b0;
                a = a + 32'd4;
                k++;
            end
        end
        // R5 R6 R7: {busy,valid,done,wb_valid}
        check("R5", {60'd0, busy_o, beat_valid_o, done_o, wb_valid_o},
              {60'd0, 1'b0, 1'b0, 1'b1, (wb && n != 0)});
        if (wb && n != 0) check("R6", {32'd0, wb_base_o}, {32'd0, exp_wb});
        @(negedge clk);
        check("R8", {62'd0, busy_o, done_o}, 64'd0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [50:0] v;
        repeat (3) @(negedge clk);
        // R1 reset held
        check("R1", {60'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", {60'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 64'd0);

        for (int t = 0; t < 8; t++) begin
            v = VECS[t];
            run_case(v[50:49], v[48], v[47:32], v[31:0], -1);
        end

        for (int t = 0; t < 60; t++) begin
            run_case(2'(t % 4), 1'($urandom % 2), 16'($urandom), $urandom & 32'hFFFF_FFFC, -1);
        end

        // R7 empty mask, writeback requested but not given
        run_case(2'b00, 1'b1, 16'h0000, 32'h0000_7000, -1);
        run_case(2'b11, 1'b1, 16'h0000, 32'h0000_7000, -1);

        // R8 stray start during a run
        run_case(2'b01, 1'b1, 16'h0F0F, 32'h0000_9000, 1);
        run_case(2'b10, 1'b1, 16'h00F0, 32'h0000_A000, 0);

        // R6 writeback off leaves wb_valid low
        run_case(2'b11, 1'b0, 16'h00FF, 32'h0000_B000, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule